// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the SPI slave that sits in front of a byte-wide serial nonvolatile memory. It oversamples the pins with the system clock and watches for edges on the serial clock. It frames each transaction with an active-low select and decodes an 8-bit command. It then shifts in a 16-bit address or a data byte, or it streams bytes back MSB first on a serial output that has its own output-enable. A pause input can freeze the serial stream partway through a frame without losing its place.

The block does not store the array, time the programming cycle or make protection decisions. It drives single-cycle strobes to three neighbours. A status unit receives write-enable set/clear pulses and status-write data, and returns the status byte and a busy flag. A read port receives an address and returns a byte combinationally. A page-write unit receives a start pulse with the address, one pulse per data byte, and a commit pulse when select rises.

Top module: `sfe_serial_mem_front`

## Requirements
- R1: A command byte is accepted only when bits 7..4 are 0000; bit 3 is ignored, and bits 2..0 select the command: 110 set write-enable (`wen_set` pulse), 100 clear write-enable (`wen_clr` pulse), 101 status read, 001 status write, 011 array read, 010 array write. At most one neighbour strobe fires in any cycle.
- R2: Command, address and data bits move MSB first, and every command starts at a falling edge of `cs_n`.
- R3: While `cs_n` is high, `si` and `sck` activity has no effect and `so_oe` is low, including after reset.
- R4: A command byte that R1 does not accept (upper nibble not zero, or code 000 or 111) makes the block ignore the rest of the frame: no strobes fire and `so_oe` stays low until the next `cs_n` fall.
- R5: Array read takes 16 address bits, of which only the low AW bits are kept (bit 15 is ignored for AW=15). It presents them on `mem_addr` and streams `rd_data` MSB first. `so` changes only after a falling `sck` edge.
- R6: During an array read, the address advances by one after each byte and wraps from 2^AW-1 to 0.
- R7: Status read streams `status_in` repeatedly for as long as the frame lasts.
- R8: Status write delivers the byte after the command on `sr_wdata` with one `sr_wr` pulse. Later bytes in the frame are ignored.
- R9: Array write pulses `pg_start` with the address on `mem_addr`. It pulses `pg_byte` with `pg_data` for each complete data byte. On `cs_n` rise it pulses `pg_commit` only if at least one data byte arrived and no partial byte follows it.
- R10: `hold_n` is taken into account only while `sck` is low. While held, `so_oe` is low, `si` and `sck` edges are ignored, and the frame resumes where it stopped.
- R11: While `busy` is high, every command except status read is treated as an unaccepted command (R4).
- R12: Both idle clock levels work (SPI modes 0 and 3): input is sampled on rising `sck`, output changes on falling `sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| busy | input | 1 | Programming cycle in progress |
| status_in | input | 8 | Status byte to return |
| wen_set | output | 1 | Write-enable set pulse |
| wen_clr | output | 1 | Write-enable clear pulse |
| sr_wr | output | 1 | Status write pulse |
| sr_wdata | output | 8 | Status write data |
| mem_addr | output | AW | Array address for read and write start |
| rd_strobe | output | 1 | New read address presented |
| rd_data | input | 8 | Array byte at `mem_addr` |
| pg_start | output | 1 | Array write header complete |
| pg_byte | output | 1 | Array write data byte complete |
| pg_data | output | 8 | Array write data byte |
| pg_commit | output | 1 | Array write frame closed cleanly |

## Verification
The hardest case to reach from the pins is a pause that falls in the middle of a byte while the master keeps toggling `sck` and driving junk on `si`. The bench pauses once in the address phase, where a single absorbed edge would shift the address and change the returned byte. It pauses again in the data phase, just after a falling edge has already put the next bit on `so`, and checks that the enable drops and the stream picks up at the next byte. Every one of the 256 command bytes is also swept and its strobes and output activity compared with a decode computed in the bench.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   typedef enum logic [3:0] {
      PH_IDLE, PH_CMD, PH_ADDR, PH_SOUT, PH_RDATA, PH_WSR, PH_WDATA, PH_SINK, PH_IGN
   } phase_e;

   localparam logic [2:0] C_WEN_SET = 3'b110;
   localparam logic [2:0] C_WEN_CLR = 3'b100;
   localparam logic [2:0] C_ST_RD   = 3'b101;
   localparam logic [2:0] C_ST_WR   = 3'b001;
   localparam logic [2:0] C_ARR_RD  = 3'b011;
   localparam logic [2:0] C_ARR_WR  = 3'b010;

   function automatic logic op_known(input logic [7:0] op);
      return (op[7:4] == 4'h0) && (op[2:0] != 3'b000) && (op[2:0] != 3'b111);
   endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $error("sfe_sync: STAGES must be at least 2");

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{INIT}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfe_txshift.sv
module sfe_txshift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       enable,
   input  logic       fall,
   input  logic       hold_act,
   input  logic [7:0] byte_in,
   output logic       so,
   output logic       so_oe,
   output logic       took
);
   logic [7:0] sr;
   logic [2:0] cnt;
   logic       sending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         cnt     <= '0;
         sending <= 1'b0;
         so      <= 1'b0;
         so_oe   <= 1'b0;
         took    <= 1'b0;
      end else begin
         took <= 1'b0;
         if (clear) begin
            cnt     <= '0;
            sending <= 1'b0;
         end else if (fall && enable) begin
            if (cnt == 3'd0) begin
               so      <= byte_in[7];
               sr      <= {byte_in[6:0], 1'b0};
               took    <= 1'b1;
               sending <= 1'b1;
            end else begin
               so <= sr[7];
               sr <= {sr[6:0], 1'b0};
            end
            cnt <= cnt + 1'b1;
         end
         so_oe <= !clear && enable && !hold_act && (sending || fall);
      end
   end

   assert_so_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(so));
endmodule

// File: rtl/sfe_serial_mem_front.sv
module sfe_serial_mem_front
   import sfe_pkg::*;
#(
   parameter int AW          = 15,
   parameter int ADDR_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck,
   input  logic          cs_n,
   input  logic          si,
   input  logic          hold_n,
   output logic          so,
   output logic          so_oe,
   input  logic          busy,
   input  logic [7:0]    status_in,
   output logic          wen_set,
   output logic          wen_clr,
   output logic          sr_wr,
   output logic [7:0]    sr_wdata,
   output logic [AW-1:0] mem_addr,
   output logic          rd_strobe,
   input  logic [7:0]    rd_data,
   output logic          pg_start,
   output logic          pg_byte,
   output logic [7:0]    pg_data,
   output logic          pg_commit
);
   localparam int NPIN = 4;
   localparam int CW   = $clog2(ADDR_BITS) + 1;
   localparam logic [NPIN-1:0] PIN_RST = 4'b1010;  // hold_n, si, cs_n, sck

   initial assert (AW >= 1 && AW <= ADDR_BITS && ADDR_BITS >= 8)
      else $error("sfe_serial_mem_front: bad address width");

   logic [NPIN-1:0] pin_raw, pin_syn;
   logic sck_s, csn_s, si_s, hold_s;
   logic sck_d, csn_d, hold_act;
   logic rise, fall, cs_fall, cs_rise;
   logic [ADDR_BITS-1:0] shreg, sh_n;
   logic [CW-1:0] bitcnt;
   logic [AW-1:0] addr;
   logic is_rd, wr_seen, tx_en, took;
   logic [7:0] tx_byte;
   phase_e phase;
   logic unused_bits;

   assign pin_raw = {hold_n, si, cs_n, sck};

   for (genvar i = 0; i < NPIN; i++) begin : g_sync
      sfe_sync #(.STAGES(SYNC_STAGES), .INIT(PIN_RST[i])) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_syn[i]));
   end

   assign sck_s  = pin_syn[0];
   assign csn_s  = pin_syn[1];
   assign si_s   = pin_syn[2];
   assign hold_s = pin_syn[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         csn_d    <= 1'b1;
         hold_act <= 1'b0;
      end else begin
         sck_d <= sck_s;
         csn_d <= csn_s;
         if (csn_s)       hold_act <= 1'b0;
         else if (!sck_s) hold_act <= ~hold_s;
      end
   end

   assign rise    = ~csn_s & ~hold_act &  sck_s & ~sck_d;
   assign fall    = ~csn_s & ~hold_act & ~sck_s &  sck_d;
   assign cs_fall = ~csn_s &  csn_d;
   assign cs_rise =  csn_s & ~csn_d;
   assign sh_n    = {shreg[ADDR_BITS-2:0], si_s};
   assign unused_bits = ^sh_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE; bitcnt <= '0; shreg <= '0; addr <= '0;
         is_rd <= 1'b0; wr_seen <= 1'b0;
         wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; sr_wdata <= '0;
         rd_strobe <= 1'b0; pg_start <= 1'b0; pg_byte <= 1'b0;
         pg_data <= '0; pg_commit <= 1'b0;
      end else begin
         wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; rd_strobe <= 1'b0;
         pg_start <= 1'b0; pg_byte <= 1'b0; pg_commit <= 1'b0;
         if (csn_s) begin
            if (cs_rise && phase == PH_WDATA && wr_seen && bitcnt == '0)
               pg_commit <= 1'b1;
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            wr_seen <= 1'b0;
         end else if (cs_fall) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
         end else begin
            if (rise) begin
               shreg  <= sh_n;
               bitcnt <= bitcnt + 1'b1;
               case (phase)
                  PH_CMD: if (bitcnt == CW'(7)) begin
                     bitcnt <= '0;
                     if (!op_known(sh_n[7:0]) || (busy && sh_n[2:0] != C_ST_RD))
                        phase <= PH_IGN;
                     else begin
                        case (sh_n[2:0])
                           C_WEN_SET: begin wen_set <= 1'b1; phase <= PH_SINK; end
                           C_WEN_CLR: begin wen_clr <= 1'b1; phase <= PH_SINK; end
                           C_ST_RD:   phase <= PH_SOUT;
                           C_ST_WR:   phase <= PH_WSR;
                           C_ARR_RD:  begin is_rd <= 1'b1; phase <= PH_ADDR; end
                           C_ARR_WR:  begin is_rd <= 1'b0; phase <= PH_ADDR; end
                           default:   phase <= PH_IGN;
                        endcase
                     end
                  end
                  PH_ADDR: if (bitcnt == CW'(ADDR_BITS - 1)) begin
                     bitcnt <= '0;
                     addr   <= sh_n[AW-1:0];
                     if (is_rd) begin phase <= PH_RDATA; rd_strobe <= 1'b1; end
                     else       begin phase <= PH_WDATA; pg_start  <= 1'b1; end
                  end
                  PH_WSR: if (bitcnt == CW'(7)) begin
                     sr_wr    <= 1'b1;
                     sr_wdata <= sh_n[7:0];
                     phase    <= PH_SINK;
                  end
                  PH_WDATA: if (bitcnt == CW'(7)) begin
                     bitcnt  <= '0;
                     pg_byte <= 1'b1;
                     pg_data <= sh_n[7:0];
                     wr_seen <= 1'b1;
                  end
                  default: ;
               endcase
            end
            if (took && phase == PH_RDATA) begin
               addr      <= addr + 1'b1;
               rd_strobe <= 1'b1;
            end
         end
      end
   end

   assign tx_en    = (phase == PH_SOUT) || (phase == PH_RDATA);
   assign tx_byte  = (phase == PH_SOUT) ? status_in : rd_data;
   assign mem_addr = addr;

   sfe_txshift u_tx (
      .clk(clk), .rst_n(rst_n), .clear(csn_s), .enable(tx_en), .fall(fall),
      .hold_act(hold_act), .byte_in(tx_byte), .so(so), .so_oe(so_oe), .took(took));

   assert_cs_idle_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !so_oe);
   assert_ignored_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGN) |=> !(wen_set || wen_clr || sr_wr || pg_start || pg_byte ||
                              rd_strobe || so_oe));
   assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wen_set, wen_clr, sr_wr, pg_start, pg_byte, pg_commit}));
   assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_set || wen_clr) |-> !$past(busy));
   assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && !csn_s) |=> ($stable(bitcnt) && $stable(phase)));
endmodule

// File: tb/sim_sfe_serial_mem_front.sv
module sim_sfe_serial_mem_front;
   localparam int AW   = 15;
   localparam int HALF = 5;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic busy = 1'b0;
   logic [7:0] status_in = 8'hC3;
   logic [7:0] rd_data;
   logic so, so_oe, wen_set, wen_clr, sr_wr, rd_strobe, pg_start, pg_byte, pg_commit;
   logic [7:0] sr_wdata, pg_data;
   logic [AW-1:0] mem_addr;

   always #5 clk = ~clk;

   sfe_serial_mem_front #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .busy(busy), .status_in(status_in),
      .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
      .mem_addr(mem_addr), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .pg_start(pg_start), .pg_byte(pg_byte), .pg_data(pg_data), .pg_commit(pg_commit));

   function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h96;
   endfunction
   assign rd_data = mem_f(mem_addr);

   int n_wen = 0, n_wrdi = 0, n_srwr = 0, n_start = 0, n_byte = 0, n_commit = 0, n_oe = 0;
   logic [7:0] last_sr = '0, last_pd = '0;
   logic [AW-1:0] last_pa = '0;
   always @(posedge clk) begin
      if (wen_set)   n_wen++;
      if (wen_clr)   n_wrdi++;
      if (sr_wr)     begin n_srwr++; last_sr = sr_wdata; end
      if (pg_start)  begin n_start++; last_pa = mem_addr; end
      if (pg_byte)   begin n_byte++; last_pd = pg_data; end
      if (pg_commit) n_commit++;
      if (so_oe)     n_oe++;
   end

   int n_chk = 0, n_fail = 0;
   int b_wen, b_wrdi, b_srwr, b_start, b_byte, b_commit, b_oe;
   bit m3 = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic snap();
      b_wen = n_wen; b_wrdi = n_wrdi; b_srwr = n_srwr; b_start = n_start;
      b_byte = n_byte; b_commit = n_commit; b_oe = n_oe;
   endtask

   function automatic logic [31:0] pack7(input int a, b, c, d, e, f, g);
      return {4'(a), 4'(b), 4'(c), 4'(d), 4'(e), 4'(f), 4'(g), 4'h0};
   endfunction

   function automatic logic [31:0] deltas();
      return pack7(n_wen - b_wen, n_wrdi - b_wrdi, n_srwr - b_srwr, n_start - b_start,
                   n_byte - b_byte, n_commit - b_commit, (n_oe > b_oe) ? 1 : 0);
   endfunction

   task automatic xbit(input logic b, output logic r);
      sck = 1'b0; si = b; wclk(HALF);
      r = so;
      sck = 1'b1; wclk(HALF);
   endtask

   task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         logic x;
         xbit(t[i], x);
         r[i] = x;
      end
   endtask

   task automatic fbegin();
      sck = m3; wclk(4);
      cs_n = 1'b0; wclk(4);
   endtask

   task automatic fend();
      if (!m3) begin sck = 1'b0; wclk(HALF); end
      cs_n = 1'b1; wclk(8);
   endtask

   task automatic hold_pause();
      int t;
      sck = 1'b0; wclk(HALF);
      hold_n = 1'b0; wclk(HALF);
      t = n_oe;
      for (int k = 0; k < 6; k++) begin
         sck = 1'b1; si = ~si; wclk(HALF);
         sck = 1'b0; si = ~si; wclk(HALF);
      end
      chk(n_oe == t, "R10 output released while held", n_oe - t, 0);
      hold_n = 1'b1; wclk(HALF);
   endtask

   task automatic run_op(input logic [7:0] op);
      logic [7:0] b1, b2, b3, r0, r1, r2, r3;
      logic [AW-1:0] a;
      bit known;
      logic [31:0] e;
      string pfx;
      pfx = m3 ? "R12 " : "";
      b1 = op ^ 8'h3C; b2 = ~op; b3 = op + 8'd7;
      a = AW'({b1, b2});
      known = (op[7:4] == 4'h0) && (op[2:0] != 3'b000) && (op[2:0] != 3'b111);
      snap();
      fbegin();
      xbyte(op, r0); xbyte(b1, r1); xbyte(b2, r2); xbyte(b3, r3);
      fend();
      e = pack7(0, 0, 0, 0, 0, 0, 0);
      if (known) begin
         case (op[2:0])
            3'b110: e = pack7(1, 0, 0, 0, 0, 0, 0);
            3'b100: e = pack7(0, 1, 0, 0, 0, 0, 0);
            3'b101: e = pack7(0, 0, 0, 0, 0, 0, 1);
            3'b001: e = pack7(0, 0, 1, 0, 0, 0, 0);
            3'b011: e = pack7(0, 0, 0, 0, 0, 0, 1);
            default: e = pack7(0, 0, 0, 1, 1, 1, 0);
         endcase
      end
      chk(deltas() == e, {pfx, known ? "R1 decode" : "R4 rejected opcode"}, deltas(), e);
      if (known && op[2:0] == 3'b101)
         chk(r1 == status_in && r2 == status_in && r3 == status_in, {pfx, "R7 status stream"},
             {8'h0, r1, r2, r3}, {8'h0, status_in, status_in, status_in});
      if (known && op[2:0] == 3'b011)
         chk(r3 == mem_f(a), {pfx, "R2/R5 read data"}, r3, mem_f(a));
      if (known && op[2:0] == 3'b001)
         chk(last_sr == b1, {pfx, "R8 status write data"}, last_sr, b1);
      if (known && op[2:0] == 3'b010)
         chk(last_pa == a && last_pd == b3, {pfx, "R9 write address/data"},
             {last_pa, last_pd}, {a, b3});
   endtask

   initial begin
      logic [7:0] r, q;
      logic [AW-1:0] a;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      chk(so_oe == 1'b0, "R3 reset output enable", so_oe, 0);
      chk(n_wen + n_wrdi + n_srwr + n_start + n_byte + n_commit == 0, "R3 reset strobes",
          n_wen + n_wrdi + n_srwr + n_start + n_byte + n_commit, 0);

      m3 = 1'b0;
      for (int op = 0; op < 256; op++) run_op(8'(op));
      m3 = 1'b1;
      for (int op = 0; op < 16; op++) run_op(8'(op));
      m3 = 1'b0;

      // R6: wrap from the top address
      fbegin(); xbyte(8'h03, q); xbyte(8'h7F, q); xbyte(8'hFE, q);
      for (int k = 0; k < 4; k++) begin
         xbyte(8'h00, r);
         a = AW'(15'h7FFE + k);
         chk(r == mem_f(a), "R6 wrap", r, mem_f(a));
      end
      fend();
      // R5: bit 15 ignored, and R1: bit 3 ignored
      fbegin(); xbyte(8'h0B, q); xbyte(8'hFF, q); xbyte(8'hFE, q);
      for (int k = 0; k < 3; k++) begin
         xbyte(8'h00, r);
         a = AW'(15'h7FFE + k);
         chk(r == mem_f(a), "R5 high address bit ignored, R1 bit 3", r, mem_f(a));
      end
      fend();

      // R9: multi-byte write, partial byte, header only
      snap();
      fbegin(); xbyte(8'h02, q); xbyte(8'h12, q); xbyte(8'h34, q);
      xbyte(8'hA1, q); xbyte(8'hB2, q); xbyte(8'hC3, q); fend();
      chk(deltas() == pack7(0, 0, 0, 1, 3, 1, 0) && last_pd == 8'hC3 && last_pa == 15'h1234,
          "R9 three-byte write", deltas(), pack7(0, 0, 0, 1, 3, 1, 0));
      snap();
      fbegin(); xbyte(8'h02, q); xbyte(8'h00, q); xbyte(8'h40, q); xbyte(8'h5A, q);
      for (int k = 0; k < 3; k++) begin logic x; xbit(1'b1, x); end
      fend();
      chk(deltas() == pack7(0, 0, 0, 1, 1, 0, 0), "R9 partial byte blocks commit",
          deltas(), pack7(0, 0, 0, 1, 1, 0, 0));
      snap();
      fbegin(); xbyte(8'h02, q); xbyte(8'h00, q); xbyte(8'h40, q); fend();
      chk(deltas() == pack7(0, 0, 0, 1, 0, 0, 0), "R9 header only, no commit",
          deltas(), pack7(0, 0, 0, 1, 0, 0, 0));

      // R11: busy
      busy = 1'b1; status_in = 8'hFF;
      snap(); fbegin(); xbyte(8'h06, q); fend();
      chk(deltas() == pack7(0, 0, 0, 0, 0, 0, 0), "R11 set-enable while busy",
          deltas(), 0);
      snap(); fbegin(); xbyte(8'h02, q); xbyte(8'h00, q); xbyte(8'h00, q); xbyte(8'h55, q); fend();
      chk(deltas() == pack7(0, 0, 0, 0, 0, 0, 0), "R11 write while busy", deltas(), 0);
      fbegin(); xbyte(8'h05, q); xbyte(8'h00, r); fend();
      chk(r == 8'hFF, "R11 status read while busy", r, 8'hFF);
      busy = 1'b0; status_in = 8'hC3;

      // R3: activity with select high
      snap();
      for (int k = 0; k < 16; k++) begin
         sck = 1'b0; si = (k % 3) != 0; wclk(HALF);
         sck = 1'b1; wclk(HALF);
      end
      sck = 1'b0; wclk(HALF);
      chk(deltas() == pack7(0, 0, 0, 0, 0, 0, 0), "R3 deselected clocks ignored", deltas(), 0);
      snap(); fbegin(); xbyte(8'h06, q); fend();
      chk(deltas() == pack7(1, 0, 0, 0, 0, 0, 0), "R3 next frame decodes", deltas(),
          pack7(1, 0, 0, 0, 0, 0, 0));

      // R4: rejected opcode then following frame
      snap(); fbegin(); xbyte(8'h16, q); xbyte(8'h06, q); xbyte(8'h05, q); xbyte(8'h03, q); fend();
      chk(deltas() == pack7(0, 0, 0, 0, 0, 0, 0), "R4 rest of frame ignored", deltas(), 0);
      snap(); fbegin(); xbyte(8'h04, q); fend();
      chk(deltas() == pack7(0, 1, 0, 0, 0, 0, 0), "R4 recovery at next select fall", deltas(),
          pack7(0, 1, 0, 0, 0, 0, 0));

      // R10: pause in address phase and in data phase
      fbegin(); xbyte(8'h03, q); xbyte(8'h21, q);
      hold_pause();
      xbyte(8'h43, q);
      xbyte(8'h00, r);
      chk(r == mem_f(15'h2143), "R10 address survives pause", r, mem_f(15'h2143));
      hold_pause();
      xbyte(8'h00, r);
      chk(r == mem_f(15'h2144), "R10 stream resumes", r, mem_f(15'h2144));
      fend();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule